// File: doc/BRIEF.md
# Auto-Increment Program Responder for a Serial Flash Device

This block is the device-side command engine of a serial flash that supports a word-pair programming mode with an automatically advancing address. It samples chip select, serial clock and serial data-in on its own system clock. It decodes opcodes, keeps a write-enable latch, a mode flag, a busy flag and a byte-pair pointer, and issues byte-write requests to a small behavioural array. Each write request carries the merged byte that is actually stored.

A host first sets the write-enable latch. It then sends the program opcode with a 24-bit address and two data bytes. While the mode stays active, each further program command carries only two data bytes, which go to the next pair of locations. The mode ends on a write-disable command, or by itself when the pair that ends at the last unprotected address has been written. The data-out line can report the status register, or it can act as a live ready/busy line while the mode is active. It is put in high impedance (enable low) whenever chip select is high.

Top module: `aai_flash_resp`

## Requirements
- R1: After reset, the status register reads 00h and the data-out enable is low.
- R2: Opcode 06h sets the write-enable latch. Opcode 04h clears both the latch and the mode flag. Opcode 05h returns the status MSB first on the byte after the opcode, with busy in bit 0, write-enable in bit 1 and the mode flag in bit 6. The mode flag is never set while the write-enable latch is clear.
- R3: A program command (ADh) sent while the write-enable latch is clear produces no write and leaves the status unchanged.
- R4: An entry program command whose 24-bit address is at or above PROT_START is ignored. No write ever targets an address at or above PROT_START.
- R5: An entry program command (ADh, three address bytes, two data bytes; executed on the rising edge of chip select) writes the first data byte to the address with bit 0 cleared and the second byte to that address plus one. Each stored byte is the old content AND the new data. The command also sets the mode flag.
- R6: After a program, busy stays high for exactly PROG_CYCLES clocks. The pointer then advances by 2, and a data-only program command (ADh plus two bytes) writes the next pair.
- R7: While the mode flag is set, only ADh, 05h and 04h take effect. Opcodes 70h, 80h and 06h are ignored.
- R8: While busy, only 05h takes effect. A 04h sent during busy leaves the mode active.
- R9: Programming the pair that ends at PROT_START-1 clears the mode flag and the write-enable latch without wrapping. A later data-only program command writes nothing.
- R10: After 70h, while the mode flag is set and chip select is low, data-out is enabled and reads 0 when busy and 1 when ready. Outside the mode it is not driven by this function.
- R11: The data-out enable is low whenever chip select is high.
- R12: Opcode 80h, accepted only outside the mode, turns the ready/busy function off. Status reads in the mode, including during busy, then come through data-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host, data taken on its rising edge |
| mosi | input | 1 | Serial data from the host, MSB first |
| so_data | output | 1 | Serial data-out level |
| so_en | output | 1 | Data-out enable; low means high impedance |
| wr_en | output | 1 | Byte-write request to the array |
| wr_addr | output | AW | Byte address of the write request |
| wr_data | output | 8 | Merged byte stored by the write request |

## Verification
The hardest state to reach from the ports is the automatic exit at the top of the unprotected region. It needs an enabled entry near the boundary, then a full busy period, then a second data-only command that lands on the final pair. The stimulus sets the write-enable latch, enters at the second-to-last pair and waits out each busy window before it sends the next command. It then shows that a further data-only command writes nothing. The AND-merge needs a location that already holds data, so the bench programs one pair in a first session and programs it again after re-entering the mode.

// File: rtl/aai_pkg.sv
`timescale 1ns/1ps
package aai_pkg;

  localparam logic [7:0] OP_PROG  = 8'hAD;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_RBON  = 8'h70;
  localparam logic [7:0] OP_RBOFF = 8'h80;

  // which opcodes may take effect in the present state
  function automatic logic op_legal(input logic [7:0] op, input logic in_mode,
                                    input logic is_busy);
    if (is_busy) return (op == OP_STAT);
    if (in_mode) return (op == OP_PROG) || (op == OP_STAT) || (op == OP_WDIS);
    return (op == OP_PROG) || (op == OP_STAT) || (op == OP_WDIS) ||
           (op == OP_WEN) || (op == OP_RBON) || (op == OP_RBOFF);
  endfunction

  // flash cells can only go from 1 to 0
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b,
                                            input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] status_byte(input logic b, input logic w,
                                             input logic m);
    return {1'b0, m, 4'b0000, w, b};
  endfunction

endpackage

// File: rtl/aai_spi_rx.sv
`timescale 1ns/1ps
module aai_spi_rx #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             mosi,
  output logic             sck_rise,
  output logic             cs_rise,
  output logic             byte_vld,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] byte_idx,
  output logic [CNT_W-1:0] nbytes
);
  logic       sck_q, cs_q;
  logic [6:0] shreg;
  logic [2:0] bitcnt;

  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      shreg    <= '0;
      bitcnt   <= '0;
      byte_vld <= 1'b0;
      byte_val <= '0;
      byte_idx <= '0;
      nbytes   <= '0;
    end else begin
      sck_q    <= sck;
      cs_q     <= cs_n;
      byte_vld <= 1'b0;
      if (cs_n) begin
        bitcnt <= '0;
        nbytes <= '0;
      end else if (sck_rise) begin
        shreg  <= {shreg[5:0], mosi};
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_val <= {shreg, mosi};
          byte_idx <= nbytes;
          if (nbytes != '1) nbytes <= nbytes + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/aai_flash_array.sv
`timescale 1ns/1ps
module aai_flash_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  assign rd_data = cells[wr_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/aai_ctrl.sv
`timescale 1ns/1ps
module aai_ctrl
  import aai_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PROT_START  = 192,
  parameter int PROG_CYCLES = 200,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_val,
  input  logic [CNT_W-1:0] byte_idx,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             cs_rise,
  input  logic             sck_rise,
  output logic             busy,
  output logic             wel,
  output logic             aai,
  output logic             hw_mode,
  output logic             rdsr_on,
  output logic [2:0]       rd_bit,
  output logic             wr_req,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_new,
  output logic             exit_top
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(PROT_START - 1);

  function automatic logic addr_locked(input logic [23:0] a);
    return a >= 24'(PROT_START);
  endfunction

  function automatic logic pair_is_last(input logic [AW-1:0] p);
    return (p + AW'(1)) == LAST_ADDR;
  endfunction

  logic [7:0]    op_q;
  logic          ok_q;
  logic [23:0]   addr_q;
  logic [7:0]    d0_q, d1_q;
  logic [AW-1:0] ptr;
  logic [TW-1:0] timer;
  logic [1:0]    wstep;

  logic is_prog, entry_go, next_go, prog_start, prog_done;

  assign is_prog    = cs_rise & ok_q & (op_q == OP_PROG);
  assign entry_go   = is_prog & ~aai & wel & (nbytes == CNT_W'(6)) & ~addr_locked(addr_q);
  assign next_go    = is_prog & aai & (nbytes == CNT_W'(3));
  assign prog_start = entry_go | next_go;
  assign prog_done  = busy & (timer == TW'(1));
  assign exit_top   = prog_done & pair_is_last(ptr);

  assign wr_req  = (wstep != 2'd0);
  assign wr_addr = {ptr[AW-1:1], wstep[1]};
  assign wr_new  = wstep[1] ? d1_q : d0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      ok_q    <= 1'b0;
      addr_q  <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      ptr     <= '0;
      timer   <= '0;
      wstep   <= '0;
      busy    <= 1'b0;
      wel     <= 1'b0;
      aai     <= 1'b0;
      hw_mode <= 1'b0;
      rdsr_on <= 1'b0;
      rd_bit  <= 3'd7;
    end else begin
      // byte capture
      if (byte_vld) begin
        if (byte_idx == '0) begin
          op_q <= byte_val;
          ok_q <= op_legal(byte_val, aai, busy);
          if (op_legal(byte_val, aai, busy) && byte_val == OP_STAT) begin
            rdsr_on <= 1'b1;
            rd_bit  <= 3'd7;
          end
        end else if (aai) begin
          if (byte_idx == CNT_W'(1)) d0_q <= byte_val;
          if (byte_idx == CNT_W'(2)) d1_q <= byte_val;
        end else begin
          if (byte_idx <= CNT_W'(3)) addr_q <= {addr_q[15:0], byte_val};
          if (byte_idx == CNT_W'(4)) d0_q <= byte_val;
          if (byte_idx == CNT_W'(5)) d1_q <= byte_val;
        end
      end else if (rdsr_on && sck_rise) begin
        rd_bit <= rd_bit - 3'd1;
      end

      // command execution at the end of the frame
      if (cs_rise) begin
        rdsr_on <= 1'b0;
        ok_q    <= 1'b0;
        if (ok_q) begin
          case (op_q)
            OP_WEN:   wel <= 1'b1;
            OP_WDIS:  begin wel <= 1'b0; aai <= 1'b0; end
            OP_RBON:  hw_mode <= 1'b1;
            OP_RBOFF: hw_mode <= 1'b0;
            default:  ;
          endcase
        end
      end

      if (prog_start) begin
        busy  <= 1'b1;
        timer <= TW'(PROG_CYCLES);
        wstep <= 2'd1;
        if (entry_go) begin
          aai <= 1'b1;
          ptr <= {addr_q[AW-1:1], 1'b0};
        end
      end else begin
        wstep <= (wstep == 2'd1) ? 2'd2 : 2'd0;
        if (busy) timer <= timer - TW'(1);
      end

      if (prog_done) begin
        busy <= 1'b0;
        if (exit_top) begin
          aai <= 1'b0;
          wel <= 1'b0;
        end else begin
          ptr <= ptr + AW'(2);
        end
      end
    end
  end
endmodule

// File: rtl/aai_flash_resp.sv
`timescale 1ns/1ps
module aai_flash_resp
  import aai_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PROT_START  = 192,
  parameter int PROG_CYCLES = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  output logic          so_data,
  output logic          so_en,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int CNT_W = 3;

  logic             sck_rise, cs_rise, byte_vld;
  logic [7:0]       byte_val;
  logic [CNT_W-1:0] byte_idx, nbytes;
  logic             busy, wel, aai, hw_mode, rdsr_on, exit_top;
  logic [2:0]       rd_bit;
  logic [7:0]       wr_new, old_byte, stat;
  logic             ryby_show, rd_show;

  aai_spi_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .sck_rise(sck_rise), .cs_rise(cs_rise), .byte_vld(byte_vld),
    .byte_val(byte_val), .byte_idx(byte_idx), .nbytes(nbytes)
  );

  aai_ctrl #(.AW(AW), .PROT_START(PROT_START), .PROG_CYCLES(PROG_CYCLES),
             .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_val(byte_val),
    .byte_idx(byte_idx), .nbytes(nbytes), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .busy(busy), .wel(wel), .aai(aai),
    .hw_mode(hw_mode), .rdsr_on(rdsr_on), .rd_bit(rd_bit), .wr_req(wr_en),
    .wr_addr(wr_addr), .wr_new(wr_new), .exit_top(exit_top)
  );

  aai_flash_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(old_byte)
  );

  assign wr_data   = prog_merge(old_byte, wr_new);
  assign stat      = status_byte(busy, wel, aai);
  assign ryby_show = hw_mode & aai & ~cs_n;
  assign rd_show   = rdsr_on & ~cs_n;
  assign so_en     = ryby_show | rd_show;
  assign so_data   = ryby_show ? ~busy : (rd_show & stat[rd_bit]);
endmodule

// File: rtl/aai_flash_resp_chk.sv
`timescale 1ns/1ps
module aai_flash_resp_chk #(
  parameter int AW          = 8,
  parameter int PROT_START  = 192,
  parameter int PROG_CYCLES = 200
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          so_en,
  input logic          so_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          busy,
  input logic          wel,
  input logic          aai,
  input logic          hw_mode,
  input logic          exit_top
);
  localparam logic [AW:0] LOCK_AT = (AW+1)'(PROT_START);
  logic [31:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 32'd1 : 32'd0;
  end

  // R11
  so_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_en);

  // R9
  top_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_top |=> (!aai && !wel));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 32'(PROG_CYCLES)));

  // R4
  prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < LOCK_AT));

  // R2
  mode_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aai |-> wel);

  // R10
  ryby_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && hw_mode && aai) |-> (so_en && (so_data == !busy)));

  // R5
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
endmodule

bind aai_flash_resp aai_flash_resp_chk #(
  .AW(AW), .PROT_START(PROT_START), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_en(so_en), .so_data(so_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy), .wel(wel), .aai(aai),
  .hw_mode(hw_mode), .exit_top(exit_top)
);

// File: tb/aai_flash_resp_tb.sv
`timescale 1ns/1ps
module aai_flash_resp_tb;
  localparam int AW    = 8;
  localparam int PROT  = 192;
  localparam int PROGC = 200;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic so_data, so_en, wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  aai_flash_resp #(.AW(AW), .PROT_START(PROT), .PROG_CYCLES(PROGC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .so_data(so_data), .so_en(so_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // behavioural model
  logic [7:0] mem_m [256];
  int  exp_a[$], exp_d[$];
  logic [7:0] tx_q[$];
  bit  wel_m = 0, aai_m = 0, hw_m = 0;
  int  ptr_m = 0, busy_left = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] st_m();
    return {1'b0, aai_m, 4'b0000, wel_m, (busy_left > 0)};
  endfunction

  function automatic bit legal_m(input logic [7:0] op);
    if (busy_left > 0) return op == 8'h05;
    if (aai_m) return op == 8'hAD || op == 8'h05 || op == 8'h04;
    return op == 8'hAD || op == 8'h05 || op == 8'h04 ||
           op == 8'h06 || op == 8'h70 || op == 8'h80;
  endfunction

  task automatic start_m(input logic [7:0] d0, input logic [7:0] d1);
    mem_m[ptr_m] = mem_m[ptr_m] & d0;
    exp_a.push_back(ptr_m);   exp_d.push_back(mem_m[ptr_m]);
    mem_m[ptr_m+1] = mem_m[ptr_m+1] & d1;
    exp_a.push_back(ptr_m+1); exp_d.push_back(mem_m[ptr_m+1]);
    busy_left = PROGC;
  endtask

  task automatic apply_m(input logic [7:0] op, input int n, input bit legal);
    int a;
    if (!legal) return;
    case (op)
      8'h06: wel_m = 1;
      8'h04: begin wel_m = 0; aai_m = 0; end
      8'h70: hw_m = 1;
      8'h80: hw_m = 0;
      8'hAD: begin
        if (!aai_m && n == 6 && wel_m) begin
          a = {8'h00, tx_q[1], tx_q[2], tx_q[3]};
          if (a < PROT) begin
            aai_m = 1;
            ptr_m = a - (a % 2);
            start_m(tx_q[4], tx_q[5]);
          end
        end else if (aai_m && n == 3) begin
          start_m(tx_q[1], tx_q[2]);
        end
      end
      default: ;
    endcase
  endtask

  // per-clock comparison, 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      bit bexp;
      bexp = (busy_left > 0);
      if (wr_en) begin
        if (exp_a.size() == 0) chk(0, "R3 unexpected write", wr_addr, 0);
        else begin
          int ea, ed;
          ea = exp_a.pop_front(); ed = exp_d.pop_front();
          chk(wr_addr == ea[AW-1:0], "R5 write address", wr_addr, ea);
          chk(wr_data == ed[7:0], "R5 merged data", wr_data, ed);
        end
      end
      if (cs_n) chk(!so_en, "R11 hiz", so_en, 0);
      else if (hw_m && aai_m)
        chk(so_en && (so_data == !bexp), "R10 ready/busy", {so_en, so_data}, {1'b1, !bexp});
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) begin
          if (ptr_m + 1 == PROT - 1) begin aai_m = 0; wel_m = 0; end
          else ptr_m = ptr_m + 2;
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, output logic [7:0] rx, output logic [7:0] ex);
    logic [7:0] s;
    rx = 8'h00; ex = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (2) @(negedge clk);
      s  = st_m();
      rx = {rx[6:0], so_data};
      ex = {ex[6:0], s[i]};
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input string req);
    logic [7:0] rx, ex, op;
    int n;
    bit legal;
    n = tx_q.size();
    op = (n > 0) ? tx_q[0] : 8'h00;
    legal = (n > 0) && legal_m(op);
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      send_byte(tx_q[k], rx, ex);
      if (k == 1 && legal && op == 8'h05) chk(rx == ex, req, rx, ex);
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    apply_m(op, n, legal);
    tx_q.delete();
    repeat (4) @(negedge clk);
  endtask

  task automatic status(input string req);
    tx_q = '{8'h05, 8'h00};
    xfer(req);
  endtask

  task automatic probe(input logic e_en, input logic e_dat, input string req);
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(so_en == e_en && (!e_en || so_data == e_dat), req, {so_en, so_data}, {e_en, e_dat});
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ready();
    repeat (PROGC + 10) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!so_en, "R1 reset enable", so_en, 0);
    status("R1 reset status");

    // R3: program with latch clear
    tx_q = '{8'hAD, 8'h00, 8'h00, 8'h20, 8'h11, 8'h22}; xfer("R3");
    status("R3 status unchanged");

    // R2: set latch
    tx_q = '{8'h06}; xfer("R2");
    status("R2 latch set");

    // R4: protected targets
    tx_q = '{8'hAD, 8'h00, 8'h00, 8'hC4, 8'h11, 8'h22}; xfer("R4");
    tx_q = '{8'hAD, 8'h01, 8'h00, 8'h10, 8'h11, 8'h22}; xfer("R4");
    status("R4 status unchanged");

    // R10 + R5: ready/busy on, entry at odd address
    tx_q = '{8'h70}; xfer("R10");
    tx_q = '{8'hAD, 8'h00, 8'h00, 8'h11, 8'hA5, 8'h3C}; xfer("R5");
    tx_q = '{8'h04}; xfer("R8");
    wait_ready();
    probe(1'b1, 1'b1, "R8 mode kept after disable during busy");
    tx_q = '{8'h80}; xfer("R7");
    probe(1'b1, 1'b1, "R7 80h ignored in mode");

    // R6: next pair
    tx_q = '{8'hAD, 8'h0F, 8'hF0}; xfer("R6");
    wait_ready();

    // R2: write-disable ends mode
    tx_q = '{8'h04}; xfer("R2");
    probe(1'b0, 1'b0, "R10 not shown outside mode");
    status("R2 after disable");

    // R12 + R5 merge
    tx_q = '{8'h80}; xfer("R12");
    tx_q = '{8'h06}; xfer("R12");
    tx_q = '{8'hAD, 8'h00, 8'h00, 8'h12, 8'hF5, 8'hFF}; xfer("R5");
    status("R12 status during busy");
    wait_ready();
    tx_q = '{8'h70}; xfer("R7");
    probe(1'b0, 1'b0, "R7 70h ignored in mode");
    tx_q = '{8'h06}; xfer("R7");
    status("R12 status in mode");

    // R9: exit at the top
    tx_q = '{8'h04}; xfer("R9");
    tx_q = '{8'h06}; xfer("R9");
    tx_q = '{8'hAD, 8'h00, 8'h00, 8'hBC, 8'h11, 8'h22}; xfer("R9");
    wait_ready();
    tx_q = '{8'hAD, 8'h33, 8'h44}; xfer("R9");
    wait_ready();
    status("R9 status after exit");
    tx_q = '{8'hAD, 8'h55, 8'h66}; xfer("R9");
    repeat (10) @(negedge clk);
    chk(exp_a.size() == 0, "R5 all writes seen", exp_a.size(), 0);
    report();
  end
endmodule